// File: doc/BRIEF.md
# External Interrupt Conditioning Unit

This unit sits between a set of external interrupt pins and a parent interrupt controller. Each of the lines has its own sense setting: active-high level, active-low level, rising edge or falling edge. Every input passes through a two-stage synchroniser. Edge events are caught in a per-line request latch. Each line drives its own active-high level output to the parent controller, gated by a per-line mask bit.

Software reaches the unit through a 32-bit register port. The port has a write strobe, a read strobe, a byte address and write data, and read data comes back combinationally. Two independent bitmaps set the sense of each line: one selects polarity, the other selects edge or level. A write-one-to-clear register removes latched requests. Software can read status both before and after masking. Edge requests are also caught while the line is masked, so software must clear stale requests before it unmasks a line.

Top module: `eicu_top`

## Requirements
- R1: After reset every mask bit is 1, all latched requests are 0 and every `irq_o` bit is 0. The polarity and edge-select bitmaps reset to 0, so a low input reads as an active raw request.
- R2: The mask register is at 0x00, and a mask bit of 1 forces the line's `irq_o` to 0. The masked status at 0x08 equals raw status AND NOT mask, and `irq_o` equals the masked status.
- R3: With edge-select (0x18) bit 0, the line is level-sensitive. Raw status (0x0C) then shows the synchronised input when polarity (0x14) is 1, and its inverse when polarity is 0.
- R4: With edge-select bit 1, the line latches a request on a rising input edge when polarity is 1, and on a falling edge when polarity is 0. The request holds after the input returns.
- R5: Writing 0x10 clears the latched request of each line whose write-data bit is 1. Bits written as 0 leave their requests unchanged, and a read of 0x10 returns 0.
- R6: An edge request latches and holds while its line is masked. It appears on `irq_o` once the mask bit is cleared.
- R7: When a clear and a newly detected edge on the same line fall in the same cycle, the request stays set.
- R8: Offsets 0x04 and 0x1C are plain read/write storage. A read of any other unlisted address returns 0, and so does any read with `reg_rd_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_i | input | NUM_LINES | Asynchronous external interrupt inputs |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | NUM_LINES | Register write data |
| reg_rdata_o | output | NUM_LINES | Register read data, combinational |
| irq_o | output | NUM_LINES | Active-high level per line to the parent controller |

## Verification
The hardest case to reach is the one where a clear write and a new edge on the same line hit the same clock edge. To get there, the bench counts synchroniser stages: it changes the input at one falling clock edge and holds the clear write two cycles later, so the write lands on the same rising edge that would latch the event. The sense settings are swept with arithmetic patterns that mix all four senses across the 32 lines at once. Each sweep step applies a before and after input pair, a partial clear and a mask pattern.

// File: rtl/eicu_pkg.sv
package eicu_pkg;
  typedef enum logic [2:0] {
    IDX_MASK   = 3'd0,
    IDX_SRCSEL = 3'd1,
    IDX_MSTAT  = 3'd2,
    IDX_RSTAT  = 3'd3,
    IDX_CLR    = 3'd4,
    IDX_POL    = 3'd5,
    IDX_EDGE   = 3'd6,
    IDX_SWI    = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/eicu_sync.sv
module eicu_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/eicu_line.sv
module eicu_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prev_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic raw_o
);
  logic lvl_act, evt, req_q;

  assign lvl_act = pol_i ? cur_i : ~cur_i;
  assign evt     = edge_i & (pol_i ? (cur_i & ~prev_i) : (~cur_i & prev_i));

  // new edge beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= evt | (req_q & ~clr_i);
  end

  assign raw_o = edge_i ? req_q : lvl_act;

  // R4
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> req_q);
  // R5
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt) |=> !req_q);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !clr_i) |=> req_q);
  // R7
  clr_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt) |=> req_q);
endmodule

// File: rtl/eicu_regs.sv
module eicu_regs
  import eicu_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      raw_i,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      edg_o,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] mask_q, src_q, pol_q, edg_q, swi_q;
  logic         hit;
  reg_idx_e     idx;

  assign hit = (addr_i[ADDR_W-1:5] == '0) && (addr_i[1:0] == 2'b00);
  assign idx = reg_idx_e'(addr_i[4:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      src_q  <= '0;
      pol_q  <= '0;
      edg_q  <= '0;
      swi_q  <= '0;
    end else if (wr_i && hit) begin
      case (idx)
        IDX_MASK:   mask_q <= wdata_i;
        IDX_SRCSEL: src_q  <= wdata_i;
        IDX_POL:    pol_q  <= wdata_i;
        IDX_EDGE:   edg_q  <= wdata_i;
        IDX_SWI:    swi_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_i && hit && idx == IDX_CLR) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_i && hit) begin
      case (idx)
        IDX_MASK:   rdata_o = mask_q;
        IDX_SRCSEL: rdata_o = src_q;
        IDX_MSTAT:  rdata_o = raw_i & ~mask_q;
        IDX_RSTAT:  rdata_o = raw_i;
        IDX_POL:    rdata_o = pol_q;
        IDX_EDGE:   rdata_o = edg_q;
        IDX_SWI:    rdata_o = swi_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign edg_o  = edg_q;

  // R2
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit && idx == IDX_MASK) |=> (mask_o == $past(wdata_i)));
  // R8
  swi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit && idx == IDX_SWI) |=> $stable(swi_q));
endmodule

// File: rtl/eicu_top.sv
module eicu_top #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] ext_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [NUM_LINES-1:0] reg_wdata_i,
  output logic [NUM_LINES-1:0] reg_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0] cur, prev, raw, mask, pol, edg, clr;

  eicu_sync #(.W(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    eicu_line u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cur_i (cur[i]),
      .prev_i(prev[i]),
      .pol_i (pol[i]),
      .edge_i(edg[i]),
      .clr_i (clr[i]),
      .raw_o (raw[i])
    );
  end

  eicu_regs #(.W(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .rd_i   (reg_rd_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .raw_i  (raw),
    .mask_o (mask),
    .pol_o  (pol),
    .edg_o  (edg),
    .clr_o  (clr),
    .rdata_o(reg_rdata_o)
  );

  assign irq_o = raw & ~mask;

  // R2
  mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & mask) == '0);
endmodule

// File: tb/tb_eicu_top.sv
module tb_eicu_top;
  localparam int CLK_NS = 10;
  localparam int N = 32;
  localparam int AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  ext_i = '0;
  logic          reg_wr_i = 1'b0;
  logic          reg_rd_i = 1'b0;
  logic [AW-1:0] reg_addr_i = '0;
  logic [N-1:0]  reg_wdata_i = '0;
  logic [N-1:0]  reg_rdata_o;
  logic [N-1:0]  irq_o;

  int nvec = 0;
  int nerr = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  eicu_top #(.NUM_LINES(N), .ADDR_W(AW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ext_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk_i);
    reg_rd_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    reg_rd_i = 1'b0;
  endtask

  function automatic logic [N-1:0] pat(input int k);
    logic [N-1:0] v;
    v = 32'h9E37_79B9 * (k + 1);
    return v ^ (v >> 13) ^ (32'(k) << 5);
  endfunction

  initial begin
    #(CLK_NS * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [N-1:0] d, pol, edg, a, b, m, c, lvl, ev, raw1, raw2;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(8'h00, d); check("R1 mask reset", d, '1);
    rd(8'h0C, d); check("R1 raw reset (low-level default)", d, '1);
    rd(8'h08, d); check("R1 masked reset", d, '0);
    check("R1 irq reset", irq_o, '0);
    rd(8'h14, d); check("R1 pol reset", d, '0);
    rd(8'h18, d); check("R1 edge reset", d, '0);

    // R8 storage and undefined reads
    wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, d); check("R8 srcsel", d, 32'hA5A5_0F0F);
    wr(8'h1C, 32'h1234_5678); rd(8'h1C, d); check("R8 swi", d, 32'h1234_5678);
    rd(8'h20, d); check("R8 undefined 0x20", d, '0);
    rd(8'h06, d); check("R8 unaligned", d, '0);
    rd(8'h10, d); check("R5 clear reads zero", d, '0);
    @(negedge clk_i); reg_addr_i = 8'h04; #1 check("R8 no rd strobe", reg_rdata_o, '0);

    // R2 R3 R4 R5 R6 sweep: mixed senses per line
    for (int k = 0; k < 24; k++) begin
      pol = pat(4*k); edg = pat(4*k+1); a = pat(4*k+2); b = pat(4*k+3);
      m = pat(100+k); c = pat(200+k);
      wr(8'h00, '1);
      wr(8'h14, pol);
      wr(8'h18, edg);
      @(negedge clk_i); ext_i = a;
      repeat (4) @(negedge clk_i);
      wr(8'h10, '1);
      @(negedge clk_i); ext_i = b;
      repeat (4) @(negedge clk_i);
      lvl = (pol & b) | (~pol & ~b);
      ev  = (pol & b & ~a) | (~pol & ~b & a);
      raw1 = (edg & ev) | (~edg & lvl);
      rd(8'h0C, d); check("R3/R4/R6 raw while masked", d, raw1);
      check("R1/R2 irq fully masked", irq_o, '0);
      wr(8'h00, m);
      rd(8'h08, d); check("R2 masked status", d, raw1 & ~m);
      #1 check("R2 irq vs mask", irq_o, raw1 & ~m);
      wr(8'h10, c);
      raw2 = (edg & ev & ~c) | (~edg & lvl);
      rd(8'h0C, d); check("R5 partial clear", d, raw2);
      wr(8'h00, '0);
      #1 check("R6 irq after unmask", irq_o, raw2);
    end

    // R7 clear and new edge on the same clock edge
    wr(8'h00, '0);
    wr(8'h14, '1);
    wr(8'h18, '1);
    @(negedge clk_i); ext_i = '0;
    repeat (4) @(negedge clk_i);
    wr(8'h10, '1);
    rd(8'h0C, d); check("R7 setup clear", d, '0);
    @(negedge clk_i); ext_i[5] = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); reg_wr_i = 1'b1; reg_addr_i = 8'h10; reg_wdata_i = 32'h0000_0020;
    @(negedge clk_i); reg_wr_i = 1'b0;
    rd(8'h0C, d); check("R7 edge wins over clear", d, 32'h0000_0020);
    wr(8'h10, 32'h0000_0020);
    rd(8'h0C, d); check("R5 later clear removes it", d, '0);
    check("R2 irq after clear", irq_o, '0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule